// File: doc/BRIEF.md
# H-Bridge Control and Sleep Sequencer

This block turns the logic-level control pins of a full-bridge motor driver into four gate commands: a high-side and a low-side switch for each of the two half-bridges, A and B. With both switches of a half-bridge off, that output floats (high impedance). The control pins are an active-low sleep request, a direction (phase) select, a drive enable, a decay-type select (fast or slow), a select for the side that carries slow-decay recirculation, and a zero-current flag from an external comparator. Every pin is treated as asynchronous and passes through a two-flop synchronizer before it is decoded.

A sequencer state machine owns the bridge. `SEQ_SLEEP` holds everything off. `SEQ_WAKE` waits out a fixed 1 ms supply-settling time, counted in clocks from the `CLK_HZ` parameter. `SEQ_RUN` decodes drive, fast decay and slow decay. `SEQ_ZHOLD` keeps the bridge floating after a zero-current event in fast decay. The transitions are: sleep-released (SLEEP to WAKE), wake-done (WAKE to RUN), zero-current-hit (RUN to ZHOLD), control-changed (ZHOLD to RUN), and sleep-asserted (any state to SLEEP).

Each half-bridge has a small dead-time state machine, with states `DRV_IDLE`, `DRV_HIGH` and `DRV_LOW`. It turns a switch off at once. It turns a switch on only after the half-bridge has been fully off for `DEAD_CYC` clocks.

Top module: `hbridge_ctrl_seq`

## Requirements
- R1: While the sleep pin is low, all four gate enables are 0 and `ready_o` is 0 no later than the fourth clock after the pin falls, whatever the other pins do.
- R2: In `SEQ_RUN` with enable high, phase high gives A high / B low (`a_hi_o=1, a_lo_o=0, b_hi_o=0, b_lo_o=1`), and phase low gives A low / B high.
- R3: With enable low and decay select low (fast decay), phase high gives A low / B high, and phase low gives A high / B low.
- R4: With enable low and decay select high (slow decay), recirculation select 0 gives both legs low (`a_lo_o=b_lo_o=1`), and 1 gives both legs high (`a_hi_o=b_hi_o=1`).
- R5: The recirculation select has no effect on the outputs while decay select is low.
- R6: In fast decay with the zero-current flag high, all four gate enables are 0. The flag has no effect in drive or slow decay.
- R7: After a zero-current event in fast decay, the outputs stay off even if the flag falls again. They return only when enable, phase, decay select or recirculation select changes.
- R8: After the sleep pin rises, all outputs stay off and `ready_o` stays 0 for at least `CLK_HZ/1000` clocks. `ready_o` then rises within 4 further clocks.
- R9: A sleep pulse during the wake wait restarts the wait from zero.
- R10: The high and low switch of one half-bridge are never on together. When a half-bridge changes between high and low, both switches are off for exactly `DEAD_CYC` clocks.
- R11: While `rst_n` is low, all four gate enables and `ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nsleep_i | input | 1 | Sleep request, 0 = sleep |
| phase_i | input | 1 | Direction select |
| enable_i | input | 1 | 1 = drive, 0 = decay |
| decay_slow_i | input | 1 | 0 = fast decay, 1 = slow decay |
| recirc_high_i | input | 1 | Slow-decay side, 1 = high side |
| zero_cur_i | input | 1 | Zero-current comparator flag |
| a_hi_o | output | 1 | Half-bridge A high-side on |
| a_lo_o | output | 1 | Half-bridge A low-side on |
| b_hi_o | output | 1 | Half-bridge B high-side on |
| b_lo_o | output | 1 | Half-bridge B low-side on |
| ready_o | output | 1 | Wake wait complete, bridge may drive |

## Verification
The properties treat the pins as asynchronous levels that, once changed, hold for several clocks. The sleep and zero-current properties therefore only claim an off bridge after a pin condition has held for five consecutive samples, which covers the synchronizer, the sequencer and the leg register. The dead-time and wake checks count clocks in the checker and never look deep into the past. The stimulus changes pins only on falling clock edges and holds each vector for ten clocks or more, well past the synchronizer and dead-time latency. Pulses shorter than that are applied only to the sleep pin, in the wake-restart test.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_LOW  = 2'd1,
        LEG_HIGH = 2'd2
    } leg_req_e;

    typedef enum logic [1:0] {
        SEQ_SLEEP = 2'd0,
        SEQ_WAKE  = 2'd1,
        SEQ_RUN   = 2'd2,
        SEQ_ZHOLD = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        DRV_IDLE = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_LOW  = 2'd2
    } drv_state_e;

    typedef struct packed {
        logic enable;
        logic phase;
        logic slow;
        logic recirc_hi;
    } ctrl_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage <= '0;
            end else begin
                stage <= {stage[0], d_i[i]};
            end
        end
        assign q_o[i] = stage[1];
    end

endmodule

// File: rtl/hb_wake_timer.sv
module hb_wake_timer #(
    parameter int unsigned WAKE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done_o = (cnt == LIMIT);

endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
    import hb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     awake_i,
    input  logic     wake_done_i,
    input  ctrl_t    ctrl_i,
    input  logic     zero_cur_i,
    output leg_req_e leg_a_o,
    output leg_req_e leg_b_o,
    output logic     ready_o
);

    seq_state_e state;
    seq_state_e state_nxt;
    ctrl_t      held;
    logic       fast_decay;
    logic       zero_hit;

    assign fast_decay = !ctrl_i.enable && !ctrl_i.slow;
    assign zero_hit   = fast_decay && zero_cur_i;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_SLEEP: if (awake_i) state_nxt = SEQ_WAKE;
            SEQ_WAKE: begin
                if (!awake_i)        state_nxt = SEQ_SLEEP;
                else if (wake_done_i) state_nxt = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (!awake_i)     state_nxt = SEQ_SLEEP;
                else if (zero_hit) state_nxt = SEQ_ZHOLD;
            end
            SEQ_ZHOLD: begin
                if (!awake_i)           state_nxt = SEQ_SLEEP;
                else if (ctrl_i != held) state_nxt = SEQ_RUN;
            end
            default: state_nxt = SEQ_SLEEP;
        endcase
    end

    // State register, with the control word captured on entry to ZHOLD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_SLEEP;
            held  <= '0;
        end else begin
            state <= state_nxt;
            if (state == SEQ_RUN && state_nxt == SEQ_ZHOLD) begin
                held <= ctrl_i;
            end
        end
    end

    // Output decode
    always_comb begin
        leg_a_o = LEG_OFF;
        leg_b_o = LEG_OFF;
        ready_o = 1'b0;
        unique case (state)
            SEQ_SLEEP, SEQ_WAKE: begin
                leg_a_o = LEG_OFF;
                leg_b_o = LEG_OFF;
            end
            SEQ_RUN: begin
                ready_o = 1'b1;
                if (ctrl_i.enable) begin
                    leg_a_o = ctrl_i.phase ? LEG_HIGH : LEG_LOW;
                    leg_b_o = ctrl_i.phase ? LEG_LOW  : LEG_HIGH;
                end else if (!ctrl_i.slow) begin
                    if (!zero_cur_i) begin
                        leg_a_o = ctrl_i.phase ? LEG_LOW  : LEG_HIGH;
                        leg_b_o = ctrl_i.phase ? LEG_HIGH : LEG_LOW;
                    end
                end else begin
                    leg_a_o = ctrl_i.recirc_hi ? LEG_HIGH : LEG_LOW;
                    leg_b_o = ctrl_i.recirc_hi ? LEG_HIGH : LEG_LOW;
                end
            end
            SEQ_ZHOLD: ready_o = 1'b1;
            default: ready_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/hb_leg_deadtime.sv
module hb_leg_deadtime
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_e req_i,
    output logic     hi_on_o,
    output logic     lo_on_o
);

    localparam int unsigned CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP = CW'(DEAD_CYC);

    drv_state_e state;
    drv_state_e state_nxt;
    logic [CW-1:0] off_cnt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            DRV_IDLE: begin
                if (off_cnt == GAP && req_i == LEG_HIGH)     state_nxt = DRV_HIGH;
                else if (off_cnt == GAP && req_i == LEG_LOW) state_nxt = DRV_LOW;
            end
            DRV_HIGH: if (req_i != LEG_HIGH) state_nxt = DRV_IDLE;
            DRV_LOW:  if (req_i != LEG_LOW)  state_nxt = DRV_IDLE;
            default:  state_nxt = DRV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= DRV_IDLE;
            off_cnt <= GAP;
        end else begin
            state <= state_nxt;
            if (state_nxt == DRV_IDLE) begin
                if (state != DRV_IDLE) begin
                    off_cnt <= CW'(1);
                end else if (off_cnt != GAP) begin
                    off_cnt <= off_cnt + CW'(1);
                end
            end
        end
    end

    always_comb begin
        hi_on_o = 1'b0;
        lo_on_o = 1'b0;
        unique case (state)
            DRV_IDLE: ;
            DRV_HIGH: hi_on_o = 1'b1;
            DRV_LOW:  lo_on_o = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/hbridge_ctrl_seq.sv
module hbridge_ctrl_seq
    import hb_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nsleep_i,
    input  logic phase_i,
    input  logic enable_i,
    input  logic decay_slow_i,
    input  logic recirc_high_i,
    input  logic zero_cur_i,
    output logic a_hi_o,
    output logic a_lo_o,
    output logic b_hi_o,
    output logic b_lo_o,
    output logic ready_o
);

    localparam int unsigned WAKE_CYCLES = CLK_HZ / 1000;
    localparam int unsigned N_PINS      = 6;
    localparam int unsigned N_LEGS      = 2;

    logic [N_PINS-1:0] pins_raw;
    logic [N_PINS-1:0] pins_s;
    ctrl_t             ctrl_s;
    logic              wake_done;
    leg_req_e          leg_req [N_LEGS];
    logic              hi_on   [N_LEGS];
    logic              lo_on   [N_LEGS];

    assign pins_raw = {nsleep_i, enable_i, phase_i, decay_slow_i, recirc_high_i, zero_cur_i};

    hb_sync #(.WIDTH(N_PINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign ctrl_s.enable    = pins_s[4];
    assign ctrl_s.phase     = pins_s[3];
    assign ctrl_s.slow      = pins_s[2];
    assign ctrl_s.recirc_hi = pins_s[1];

    hb_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) wake_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (pins_s[5]),
        .done_o (wake_done)
    );

    hb_seq_fsm seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .awake_i     (pins_s[5]),
        .wake_done_i (wake_done),
        .ctrl_i      (ctrl_s),
        .zero_cur_i  (pins_s[0]),
        .leg_a_o     (leg_req[0]),
        .leg_b_o     (leg_req[1]),
        .ready_o     (ready_o)
    );

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        hb_leg_deadtime #(.DEAD_CYC(DEAD_CYC)) leg_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (leg_req[g]),
            .hi_on_o (hi_on[g]),
            .lo_on_o (lo_on[g])
        );
    end

    assign a_hi_o = hi_on[0];
    assign a_lo_o = lo_on[0];
    assign b_hi_o = hi_on[1];
    assign b_lo_o = lo_on[1];

endmodule

// File: rtl/hbridge_ctrl_seq_chk.sv
module hbridge_ctrl_seq_chk #(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned DEAD_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic nsleep_i,
    input logic enable_i,
    input logic decay_slow_i,
    input logic zero_cur_i,
    input logic a_hi_o,
    input logic a_lo_o,
    input logic b_hi_o,
    input logic b_lo_o,
    input logic ready_o
);

    localparam int unsigned WAKE_CYCLES = CLK_HZ / 1000;
    localparam int unsigned AWAKE_SAT   = WAKE_CYCLES + 4;

    logic [3:0]  drv;
    int unsigned idle [4];
    int unsigned awake_cnt;
    logic        fast_zero;

    assign drv       = {a_hi_o, a_lo_o, b_hi_o, b_lo_o};
    assign fast_zero = !enable_i && !decay_slow_i && zero_cur_i;

    // Clocks since each switch was last seen on (saturating)
    for (genvar k = 0; k < 4; k++) begin : g_idle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idle[k] <= DEAD_CYC;
            end else if (drv[k]) begin
                idle[k] <= 0;
            end else if (idle[k] < DEAD_CYC) begin
                idle[k] <= idle[k] + 1;
            end
        end
    end

    // Consecutive clocks the sleep pin has been high (saturating)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            awake_cnt <= 0;
        end else if (!nsleep_i) begin
            awake_cnt <= 0;
        end else if (awake_cnt < AWAKE_SAT) begin
            awake_cnt <= awake_cnt + 1;
        end
    end

    p_sleep_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nsleep_i && !$past(nsleep_i) && !$past(nsleep_i, 2) && !$past(nsleep_i, 3) && !$past(nsleep_i, 4))
        |-> (drv == 4'b0000 && !ready_o));

    p_zero_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_zero && $past(fast_zero) && $past(fast_zero, 2) && $past(fast_zero, 3) && $past(fast_zero, 4))
        |-> (drv == 4'b0000));

    p_wake_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (awake_cnt >= WAKE_CYCLES));

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi_o && a_lo_o) && !(b_hi_o && b_lo_o));

    p_gap_a_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_lo_o) |-> (idle[3] >= DEAD_CYC));

    p_gap_a_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_hi_o) |-> (idle[2] >= DEAD_CYC));

    p_gap_b_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_lo_o) |-> (idle[1] >= DEAD_CYC));

    p_gap_b_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_hi_o) |-> (idle[0] >= DEAD_CYC));

    // R11: everything off while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_off_r11: assert (drv == 4'b0000 && !ready_o);
        end
    end

endmodule

bind hbridge_ctrl_seq hbridge_ctrl_seq_chk #(
    .CLK_HZ   (CLK_HZ),
    .DEAD_CYC (DEAD_CYC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .nsleep_i     (nsleep_i),
    .enable_i     (enable_i),
    .decay_slow_i (decay_slow_i),
    .zero_cur_i   (zero_cur_i),
    .a_hi_o       (a_hi_o),
    .a_lo_o       (a_lo_o),
    .b_hi_o       (b_hi_o),
    .b_lo_o       (b_lo_o),
    .ready_o      (ready_o)
);

// File: tb/hbridge_ctrl_seq_tb_top.sv
module hbridge_ctrl_seq_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned CLK_HZ     = 20_000;
    localparam int unsigned DEAD_CYC   = 2;
    localparam int unsigned WAKE       = CLK_HZ / 1000;
    localparam int unsigned HOLD       = 10;
    localparam int unsigned N_VEC      = 15;
    localparam int unsigned WATCHDOG   = 20_000;

    // Vector: {enable, phase, slow, recirc_hi, zero_cur, a_hi, a_lo, b_hi, b_lo}
    localparam logic [8:0] VEC [N_VEC] = '{
        9'b11000_1001, // R2 forward
        9'b10000_0110, // R2 reverse
        9'b11110_1001, // R2 drive ignores decay inputs
        9'b01000_0110, // R3 fast decay, phase high
        9'b01010_0110, // R5 recirc changed in fast decay
        9'b00000_1001, // R3 fast decay, phase low
        9'b00100_0101, // R4 slow low side
        9'b01100_0101, // R4 slow low side, phase high
        9'b01110_1010, // R4 slow high side
        9'b01111_1010, // R6 zero flag ignored in slow decay
        9'b11001_1001, // R6 zero flag ignored in drive
        9'b01001_0000, // R6 fast decay hits zero current
        9'b01000_0000, // R7 latched after flag falls
        9'b01010_0110, // R7 recirc change releases
        9'b00010_1001  // R5 recirc high, fast decay, phase low
    };
    localparam int VREQ [N_VEC] = '{2, 2, 2, 3, 5, 3, 4, 4, 4, 6, 6, 6, 7, 7, 5};

    logic clk = 1'b0;
    logic rst_n;
    logic nsleep, phase, enable, slow, recirc, zcur;
    logic a_hi, a_lo, b_hi, b_lo, ready;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hbridge_ctrl_seq #(
        .CLK_HZ   (CLK_HZ),
        .DEAD_CYC (DEAD_CYC)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .nsleep_i      (nsleep),
        .phase_i       (phase),
        .enable_i      (enable),
        .decay_slow_i  (slow),
        .recirc_high_i (recirc),
        .zero_cur_i    (zcur),
        .a_hi_o        (a_hi),
        .a_lo_o        (a_lo),
        .b_hi_o        (b_hi),
        .b_lo_o        (b_lo),
        .ready_o       (ready)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (a_hi a_lo b_hi b_lo ready)", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {a_hi, a_lo, b_hi, b_lo, ready};
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic [4:0] c);
        {enable, phase, slow, recirc, zcur} = c;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n  = 1'b0;
        nsleep = 1'b0;
        set_ctrl(5'b11000);
        cycles(3);
        check("R11 reset state", outs(), 5'b00000);
        @(negedge clk) rst_n = 1'b1;
        nsleep = 1'b1;

        // R9: short sleep pulse during the wake wait restarts it
        cycles(WAKE - 5);
        nsleep = 1'b0;
        cycles(3);
        nsleep = 1'b1;
        cycles(WAKE);
        check("R9 wait restarted", outs(), 5'b00000);

        // R8: ready within 4 clocks of the full wait
        cycles(4);
        check("R8 ready after wait", outs() & 5'b00001, 5'b00001);

        // Fresh wake for a clean R8 window
        nsleep = 1'b0;
        cycles(6);
        nsleep = 1'b1;
        cycles(WAKE);
        check("R8 off during wait", outs(), 5'b00000);
        cycles(4);
        check("R8 ready", outs(), 5'b10011);

        // Vector table
        for (int v = 0; v < N_VEC; v++) begin
            set_ctrl(VEC[v][8:4]);
            cycles(HOLD);
            check($sformatf("R%0d vector %0d", VREQ[v], v), outs(), {VEC[v][3:0], 1'b1});
        end

        // R10: phase reversal in drive, count the off window of each leg
        set_ctrl(5'b11000);
        cycles(HOLD);
        check("R10 forward before reversal", outs(), 5'b10011);
        begin
            int off_a = 0;
            int off_b = 0;
            int overlap = 0;
            phase = 1'b0;
            for (int s = 0; s < 14; s++) begin
                @(negedge clk);
                if (!a_hi && !a_lo) off_a++;
                if (!b_hi && !b_lo) off_b++;
                if ((a_hi && a_lo) || (b_hi && b_lo)) overlap++;
            end
            check("R10 leg A dead time", 5'(off_a), 5'(DEAD_CYC));
            check("R10 leg B dead time", 5'(off_b), 5'(DEAD_CYC));
            check("R10 no overlap", 5'(overlap), 5'd0);
            check("R10 reverse after reversal", outs(), 5'b01101);
        end

        // R1: sleep forces everything off, whatever the other pins do
        nsleep = 1'b0;
        cycles(5);
        check("R1 sleep off", outs(), 5'b00000);
        set_ctrl(5'b01100);
        cycles(HOLD);
        check("R1 sleep off, slow decay pins", outs(), 5'b00000);
        set_ctrl(5'b11000);
        cycles(HOLD);
        check("R1 sleep off, drive pins", outs(), 5'b00000);

        // R11: reset in the middle of operation
        nsleep = 1'b1;
        cycles(WAKE + 8);
        check("R11 running before reset", outs(), 5'b10011);
        rst_n = 1'b0;
        #1;
        check("R11 reset mid-run", outs(), 5'b00000);
        cycles(2);
        rst_n = 1'b1;
        cycles(2);
        check("R11 off after reset release", outs(), 5'b00000);

        finish_run();
    end

endmodule